// File: doc/BRIEF.md
# Nonvolatile Byte Store Write Controller

This block sits between a processor's register bus and a 64-byte nonvolatile data array. Software reaches it through four byte-wide registers: a cell address, a data byte, a control byte and a key register. A read is requested by setting one control bit. The addressed byte lands in the data register one clock later.

A write is deliberately hard to trigger by accident. The write-enable bit must already be set. The two bus accesses just before the one that sets the write-start bit must be writes of 0x55 and then 0xAA to the key register. Once a write is accepted, it holds the array busy for a parameterised number of clock cycles. It then stores the byte, raises a sticky completion flag and emits a one-cycle pulse for the interrupt logic.

There are two reset inputs. A power-on reset clears everything except the array. A warm reset, which stands for a pin or watchdog reset, aborts a write in progress and records the abort in an error flag. In this model the array is a plain register array.

Top module: `nvs_ctrl`

## Requirements
- R1: `bus_sel` selects the register: 0 address, 1 data, 2 control, 3 key. The address register keeps 6 bits and reads back zero-extended, so cells 0x00 to 0x3F are reachable.
- R2: Control bits are: bit 0 read-start, bit 1 write-start, bit 2 write-enable, bit 3 write-error, bit 4 write-complete. Bits 7..5 always read as 0.
- R3: Software can set the read-start and write-start bits but cannot clear them. Writing 0 to a start bit while its operation runs leaves the bit at 1.
- R4: A write starts only when two conditions hold. First, the two bus accesses just before the control write that sets bit 1 are writes of 0x55 and then 0xAA to the key register. Second, write-enable is already 1. Any other access in between, a reversed order, or write-enable at 0 leaves the write-start bit at 0 and the array untouched.
- R5: The key register has no storage and always reads 0.
- R6: Power-on reset clears the address, data and control registers, including write-enable and both flags.
- R7: A warm reset during a write aborts it. The cell keeps its old value, write-start clears, write-error is set and no completion pulse occurs. Write-enable survives a warm reset.
- R8: Write-start stays set for exactly WR_CYCLES cycles. `done_pulse` is high for one cycle, exactly WR_CYCLES clock edges after the edge that accepted the write, and the completion flag is set at that same edge.
- R9: The error and completion flags stay set until software writes 0 to them. Writing 1 to either flag never sets it.
- R10: A read request sets read-start for one cycle. The data register is loaded from the addressed cell at the next edge, and read-start then reads 0.
- R11: A read request made while a write is running is ignored: read-start stays 0 and the data register keeps its value.
- R12: A write stores the address and data that were held when it was accepted. Later changes to those registers do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| warm_rst | input | 1 | Pin or watchdog reset, synchronous, active high |
| bus_sel | input | 2 | Register select |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (counts as an access for the key sequence) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register (combinational) |
| done_pulse | output | 1 | One-cycle write completion pulse |

## Verification
Register reads are combinational, so a read returns the state after the last edge. Read-start is visible in the cycle right after the control write, and the loaded data byte one cycle after that. The bench drives every access from the falling edge and samples one time step later, so each read sees the state after the previous rising edge. It records the cycle number of the edge that accepted a write and the cycle in which `done_pulse` is seen, and it requires their difference to equal WR_CYCLES exactly. For the ignored cases (broken key sequences, write-enable low, a read during a write, a warm-reset abort), the bench waits longer than a full write and then checks the control bits, the pulse count and the cell contents.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  localparam int DW = 8;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_UNLK = 2'd3
  } reg_sel_e;

  localparam int CB_RD   = 0;
  localparam int CB_WR   = 1;
  localparam int CB_WE   = 2;
  localparam int CB_ERR  = 3;
  localparam int CB_DONE = 4;

  localparam logic [DW-1:0] KEY_FIRST  = 8'h55;
  localparam logic [DW-1:0] KEY_SECOND = 8'hAA;

  typedef enum logic [1:0] {
    UL_IDLE  = 2'd0,
    UL_HALF  = 2'd1,
    UL_ARMED = 2'd2
  } ulk_e;

  // Next key-sequence state for one bus cycle.
  function automatic ulk_e unlock_next(ulk_e st, logic acc, logic is_wr,
                                       reg_sel_e sel, logic [DW-1:0] d);
    ulk_e nx;
    if (!acc)
      nx = st;
    else if (is_wr && sel == SEL_UNLK && d == KEY_FIRST)
      nx = UL_HALF;
    else if (st == UL_HALF && is_wr && sel == SEL_UNLK && d == KEY_SECOND)
      nx = UL_ARMED;
    else
      nx = UL_IDLE;
    return nx;
  endfunction

  // Control byte image; unused upper bits are zero.
  function automatic logic [DW-1:0] ctrl_pack(logic rd, logic wr, logic we,
                                              logic err, logic done);
    logic [DW-1:0] v;
    v          = '0;
    v[CB_RD]   = rd;
    v[CB_WR]   = wr;
    v[CB_WE]   = we;
    v[CB_ERR]  = err;
    v[CB_DONE] = done;
    return v;
  endfunction

endpackage

// File: rtl/nvs_unlock.sv
module nvs_unlock
  import nvs_pkg::*;
(
  input  logic          clk,
  input  logic          por_n,
  input  logic          warm_rst,
  input  logic          acc,
  input  logic          is_wr,
  input  reg_sel_e      sel,
  input  logic [DW-1:0] wdata,
  output logic          armed
);

  ulk_e st_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      st_q <= UL_IDLE;
    else if (warm_rst)
      st_q <= UL_IDLE;
    else
      st_q <= unlock_next(st_q, acc, is_wr, sel, wdata);
  end

  assign armed = (st_q == UL_ARMED);

  // R4
  arm_after_second_key_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(armed) |-> $past(acc && is_wr && sel == SEL_UNLK && wdata == KEY_SECOND));

  // R4
  arm_dropped_on_access_chk: assert property (@(posedge clk) disable iff (!por_n)
    (armed && acc && !warm_rst) |=> !armed);

endmodule

// File: rtl/nvs_wtimer.sv
module nvs_wtimer #(
  parameter int CYC = 500000
) (
  input  logic clk,
  input  logic por_n,
  input  logic warm_rst,
  input  logic start,
  output logic busy,
  output logic expire
);

  localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [CW-1:0] LOAD = CW'(CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (warm_rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= LOAD;
    end else if (busy_q) begin
      if (cnt_q == '0)
        busy_q <= 1'b0;
      else
        cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy   = busy_q;
  assign expire = busy_q && (cnt_q == '0) && !warm_rst;

  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (!por_n)
    start |-> !busy);

  // R8
  busy_ends_after_expire_chk: assert property (@(posedge clk) disable iff (!por_n)
    expire |=> !busy);

endmodule

// File: rtl/nvs_array.sv
module nvs_array #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          wen,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wen)
      mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/nvs_ctrl.sv
module nvs_ctrl
  import nvs_pkg::*;
#(
  parameter int WR_CYCLES = 500000,
  parameter int AW        = 6
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          warm_rst,
  input  logic [1:0]    bus_sel,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          done_pulse
);

  localparam int PADW = DW - AW;

  reg_sel_e      sel;
  logic          acc, ctrl_wr, armed;
  logic          wr_start, rd_req, wr_busy, wr_expire;
  logic [AW-1:0] addr_q, wa_q;
  logic [DW-1:0] data_q, wd_q, cell_rd;
  logic          rd_q, we_q, err_q, done_q, pulse_q;

  assign sel      = reg_sel_e'(bus_sel);
  assign acc      = bus_wr || bus_rd;
  assign ctrl_wr  = bus_wr && (sel == SEL_CTRL);
  assign wr_start = ctrl_wr && bus_wdata[CB_WR] && !wr_busy && armed && we_q;
  assign rd_req   = ctrl_wr && bus_wdata[CB_RD] && !wr_busy && !wr_start && !rd_q;

  nvs_unlock u_unlock (
    .clk      (clk),
    .por_n    (por_n),
    .warm_rst (warm_rst),
    .acc      (acc),
    .is_wr    (bus_wr),
    .sel      (sel),
    .wdata    (bus_wdata),
    .armed    (armed)
  );

  nvs_wtimer #(.CYC(WR_CYCLES)) u_timer (
    .clk      (clk),
    .por_n    (por_n),
    .warm_rst (warm_rst),
    .start    (wr_start),
    .busy     (wr_busy),
    .expire   (wr_expire)
  );

  nvs_array #(.AW(AW), .DW(DW)) u_array (
    .clk   (clk),
    .wen   (wr_expire),
    .waddr (wa_q),
    .wdata (wd_q),
    .raddr (addr_q),
    .rdata (cell_rd)
  );

  // Address, data and read-start: cleared by either reset.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      addr_q <= '0;
      data_q <= '0;
      rd_q   <= 1'b0;
    end else if (warm_rst) begin
      addr_q <= '0;
      data_q <= '0;
      rd_q   <= 1'b0;
    end else begin
      if (bus_wr && sel == SEL_ADDR)
        addr_q <= bus_wdata[AW-1:0];
      if (rd_q)
        data_q <= cell_rd;
      else if (bus_wr && sel == SEL_DATA)
        data_q <= bus_wdata;
      rd_q <= rd_req;
    end
  end

  // Write buffer captured at acceptance.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      wa_q <= '0;
      wd_q <= '0;
    end else if (wr_start) begin
      wa_q <= addr_q;
      wd_q <= data_q;
    end
  end

  // Enable and flags: only power-on reset clears them.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      we_q    <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else if (warm_rst) begin
      if (wr_busy)
        err_q <= 1'b1;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= wr_expire;
      if (ctrl_wr) begin
        we_q <= bus_wdata[CB_WE];
        if (!bus_wdata[CB_ERR])
          err_q <= 1'b0;
      end
      if (wr_expire)
        done_q <= 1'b1;
      else if (ctrl_wr && !bus_wdata[CB_DONE])
        done_q <= 1'b0;
    end
  end

  always_comb begin
    case (sel)
      SEL_ADDR: bus_rdata = {{PADW{1'b0}}, addr_q};
      SEL_DATA: bus_rdata = data_q;
      SEL_CTRL: bus_rdata = ctrl_pack(rd_q, wr_busy, we_q, err_q, done_q);
      default:  bus_rdata = '0;
    endcase
  end

  assign done_pulse = pulse_q;

  // R4
  start_needs_key_and_enable_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(wr_busy) |-> $past(armed && we_q));

  // R7
  abort_sets_error_chk: assert property (@(posedge clk) disable iff (!por_n)
    (warm_rst && wr_busy) |=> (err_q && !wr_busy && !done_pulse));

  // R8
  pulse_with_flag_chk: assert property (@(posedge clk) disable iff (!por_n)
    done_pulse |-> done_q);

  // R8
  pulse_single_chk: assert property (@(posedge clk) disable iff (!por_n)
    done_pulse |=> !done_pulse);

  // R2
  ctrl_upper_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
    (sel == SEL_CTRL) |-> (bus_rdata[7:5] == 3'b000));

  // R5
  key_reads_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
    (sel == SEL_UNLK) |-> (bus_rdata == '0));

  // R10
  read_one_cycle_chk: assert property (@(posedge clk) disable iff (!por_n)
    rd_q |=> !rd_q);

  // R11
  no_read_while_busy_chk: assert property (@(posedge clk) disable iff (!por_n)
    wr_busy |=> !rd_q);

endmodule

// File: tb/nvs_ctrl_test.sv
module nvs_ctrl_test;

  localparam int N = 20;
  localparam logic [1:0] S_ADDR = 2'd0, S_DATA = 2'd1, S_CTRL = 2'd2, S_KEY = 2'd3;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       warm_rst = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       done_pulse;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int pulse_cnt = 0;
  int pulse_cyc = 0;
  int start_cyc = 0;

  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (done_pulse) begin
      pulse_cnt <= pulse_cnt + 1;
      pulse_cyc <= cyc;
    end
  end

  nvs_ctrl #(.WR_CYCLES(N)) uut (
    .clk        (clk),
    .por_n      (por_n),
    .warm_rst   (warm_rst),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .done_pulse (done_pulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // All bus tasks start and end on a falling edge.
  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    bus_sel = s; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] v);
    bus_sel = s; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic keyed_write(input logic [7:0] a, input logic [7:0] d);
    wr(S_ADDR, a);
    wr(S_DATA, d);
    wr(S_CTRL, 8'h04);
    wr(S_KEY, 8'h55);
    wr(S_KEY, 8'hAA);
    wr(S_CTRL, 8'h06);
    start_cyc = cyc;
  endtask

  task automatic read_cell(input logic [7:0] a, output logic [7:0] v);
    wr(S_ADDR, a);
    wr(S_CTRL, 8'h05);
    idle(1);
    rd(S_DATA, v);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(S_ADDR, v); chk("R6 addr after por", v, 8'h00);
    rd(S_DATA, v); chk("R6 data after por", v, 8'h00);
    rd(S_CTRL, v); chk("R6 ctrl after por", v, 8'h00);
    rd(S_KEY, v);  chk("R5 key reads 0", v, 8'h00);
  endtask

  task automatic t_write_basic;
    logic [7:0] v;
    int p0;
    p0 = pulse_cnt;
    keyed_write(8'h12, 8'hA5);
    rd(S_CTRL, v); chk("R8 write-start set", v, 8'h06);
    idle(N + 2);
    chk("R8 one pulse", pulse_cnt - p0, 1);
    chk("R8 duration", pulse_cyc - start_cyc, N);
    rd(S_CTRL, v); chk("R8 done flag, start clear", v, 8'h14);
    wr(S_ADDR, 8'h12);
    wr(S_CTRL, 8'h05);
    rd(S_CTRL, v); chk("R10 read-start visible", v, 8'h05);
    rd(S_DATA, v); chk("R10 data loaded", v, 8'hA5);
    rd(S_CTRL, v); chk("R10 read-start cleared", v, 8'h04);
    keyed_write(8'h05, 8'h3C);
    idle(N + 2);
    read_cell(8'h05, v); chk("R8 second cell", v, 8'h3C);
  endtask

  task automatic t_key_negative;
    logic [7:0] v;
    int p0;
    p0 = pulse_cnt;
    // access between the two keys
    wr(S_KEY, 8'h55); rd(S_DATA, v); wr(S_KEY, 8'hAA); wr(S_CTRL, 8'h06);
    rd(S_CTRL, v); chk("R4 break between keys", v, 8'h04);
    // access between second key and start
    wr(S_KEY, 8'h55); wr(S_KEY, 8'hAA); wr(S_ADDR, 8'h12); wr(S_CTRL, 8'h06);
    rd(S_CTRL, v); chk("R4 break before start", v, 8'h04);
    // reversed order
    wr(S_KEY, 8'hAA); wr(S_KEY, 8'h55); wr(S_CTRL, 8'h06);
    rd(S_CTRL, v); chk("R4 reversed keys", v, 8'h04);
    // enable low
    wr(S_CTRL, 8'h00);
    wr(S_KEY, 8'h55); wr(S_KEY, 8'hAA); wr(S_CTRL, 8'h02);
    rd(S_CTRL, v); chk("R4 enable low", v, 8'h00);
    rd(S_KEY, v); chk("R5 key still 0", v, 8'h00);
    idle(N + 2);
    chk("R4 no pulse", pulse_cnt - p0, 0);
    wr(S_CTRL, 8'h04);
    read_cell(8'h12, v); chk("R4 cell untouched", v, 8'hA5);
  endtask

  task automatic t_busy_rules;
    logic [7:0] v;
    int p0;
    p0 = pulse_cnt;
    keyed_write(8'h05, 8'h77);
    wr(S_CTRL, 8'h04);
    rd(S_CTRL, v); chk("R3 start not clearable", v, 8'h06);
    wr(S_ADDR, 8'h12);
    wr(S_DATA, 8'h99);
    wr(S_CTRL, 8'h05);
    rd(S_CTRL, v); chk("R11 read ignored in write", v, 8'h06);
    rd(S_DATA, v); chk("R11 data kept", v, 8'h99);
    idle(N + 2);
    chk("R3 write still completes", pulse_cnt - p0, 1);
    chk("R3 duration unchanged", pulse_cyc - start_cyc, N);
    read_cell(8'h05, v); chk("R12 captured addr/data", v, 8'h77);
    read_cell(8'h12, v); chk("R12 other cell kept", v, 8'hA5);
  endtask

  task automatic t_flags_map;
    logic [7:0] v;
    keyed_write(8'h30, 8'h5A);
    idle(N + 2);
    wr(S_CTRL, 8'h14);
    rd(S_CTRL, v); chk("R9 done held by writing 1", v, 8'h14);
    wr(S_CTRL, 8'h04);
    rd(S_CTRL, v); chk("R9 done cleared by 0", v, 8'h04);
    wr(S_CTRL, 8'h1C);
    rd(S_CTRL, v); chk("R9 flags not set by 1", v, 8'h04);
    wr(S_CTRL, 8'hE4);
    rd(S_CTRL, v); chk("R2 upper bits zero", v, 8'h04);
    wr(S_ADDR, 8'hFF);
    rd(S_ADDR, v); chk("R1 address width", v, 8'h3F);
    wr(S_DATA, 8'hC3);
    rd(S_DATA, v); chk("R1 data register", v, 8'hC3);
  endtask

  task automatic t_warm_abort;
    logic [7:0] v;
    int p0;
    p0 = pulse_cnt;
    keyed_write(8'h30, 8'h11);
    idle(3);
    warm_rst = 1'b1;
    idle(1);
    warm_rst = 1'b0;
    rd(S_CTRL, v); chk("R7 abort flags", v, 8'h0C);
    idle(N + 2);
    chk("R7 no pulse", pulse_cnt - p0, 0);
    rd(S_ADDR, v); chk("R7 addr cleared", v, 8'h00);
    read_cell(8'h30, v); chk("R7 cell kept", v, 8'h5A);
    rd(S_CTRL, v); chk("R9 error cleared by 0", v, 8'h04);
  endtask

  task automatic t_por;
    logic [7:0] v;
    wr(S_CTRL, 8'h04);
    por_n = 1'b0;
    idle(2);
    por_n = 1'b1;
    idle(1);
    rd(S_CTRL, v); chk("R6 enable cleared by por", v, 8'h00);
    rd(S_DATA, v); chk("R6 data cleared by por", v, 8'h00);
  endtask

  initial begin
    idle(3);
    por_n = 1'b1;
    idle(1);
    t_reset();
    t_write_basic();
    t_key_negative();
    t_busy_rules();
    t_flags_map();
    t_warm_abort();
    t_por();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule